// File: doc/BRIEF.md
# Saturating event counter unit

This unit counts cache activity for performance analysis. Two identical 32-bit counters each choose one of up to fifteen single-cycle event lines driven by the neighbouring cache logic. A counter adds one for every pulse on its chosen line, but only while the shared enable bit is set. Counters stop at all-ones and do not wrap. Software then sees a full counter and knows that events were lost.

A small register bus gives software access to the unit. One control register holds the global enable. Each counter has a configuration register that selects its event source, and a value register that software can read or overwrite at any time. The per-counter registers are laid out in descending order, so counter 1 sits four bytes below counter 0. A build parameter selects either the base event set (codes 1 to 9) or the extended set (codes 1 to 15).

Top module: `cache_evt_counters`

## Requirements
- R1: After reset, the enable bit is 0, both event sources are 0 (off), both counters read 0 and the read data output is 0.
- R2: The register map is as follows. The control register is at 0x00, with enable at bit 0 and all other bits reading 0. Counter 1 configuration is at 0x04 and counter 0 configuration is at 0x08. Counter 1 value is at 0x0C and counter 0 value is at 0x10. A read presents its data on the cycle after the read request.
- R3: A counter that holds 0xFFFFFFFF keeps that value on further events.
- R4: While the enable bit is 0, no counter changes on events, whatever its source.
- R5: A counter whose source field (configuration bits [5:2]) is 0 never counts.
- R6: Source code c (1 to 9) counts pulses on event line c-1 only, one step per pulse.
- R7: Codes 0xA to 0xF count on lines 9 to 14 when the extended set is selected. In the base set they count nothing.
- R8: A write to a value register loads the counter, and counting then continues from the written value.
- R9: If a value register is written in the same cycle as an event for that counter, the written value wins and the event is dropped.
- R10: The interrupt-mode field (configuration bits [1:0]) ignores writes and always reads 0 (disabled). Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| evt_in | input | 15 | Event pulses; line c-1 carries source code c |

## Verification
Two functions can fall in the same clock cycle: a software write to a value register and an event pulse for the same counter. The bench raises the write strobe and the selected event line on the same cycle. It then reads the counter back, expects exactly the written value with no extra count, and confirms with a further pulse that counting resumes from there. Saturation meets the same path: events arriving at all-ones must not disturb a later reload.

// File: rtl/cache_evt_pkg.sv
package cache_evt_pkg;
    localparam int ADDR_W  = 8;
    localparam int SRC_W   = 4;
    localparam int SRC_LSB = 2;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CFG0 = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_VAL0 = 8'h10;

    // Descending layout: counter i sits 4*i bytes below counter 0.
    function automatic logic [ADDR_W-1:0] cfg_ofs(input int idx);
        return OFS_CFG0 - ADDR_W'(4 * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] val_ofs(input int idx);
        return OFS_VAL0 - ADDR_W'(4 * idx);
    endfunction

    typedef struct packed {
        logic [SRC_W-1:0] src;
    } cnt_cfg_t;
endpackage

// File: rtl/cache_evt_select.sv
module cache_evt_select #(
    parameter int NUM_EVT      = 15,
    parameter int BASE_EVT_MAX = 9,
    parameter bit EXTENDED     = 1'b1
) (
    input  logic [cache_evt_pkg::SRC_W-1:0] src,
    input  logic [NUM_EVT-1:0]              evt_in,
    output logic                            hit
);
    import cache_evt_pkg::*;

    logic legal;

    generate
        if (EXTENDED) begin : g_ext
            assign legal = (src != '0) && (int'(src) <= NUM_EVT);
        end else begin : g_base
            assign legal = (src != '0) && (int'(src) <= BASE_EVT_MAX);
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        if (legal)
            hit = evt_in[src - SRC_W'(1)];
    end
endmodule

// File: rtl/cache_evt_sat_counter.sv
module cache_evt_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    logic at_max;
    assign at_max = (count == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (inc && !at_max)
            count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/cache_evt_regbank.sv
module cache_evt_regbank #(
    parameter int CNT_W   = 32,
    parameter int NUM_CNT = 2
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  bus_sel,
    input  logic                                  bus_wr,
    input  logic [cache_evt_pkg::ADDR_W-1:0]      bus_addr,
    input  logic                                  wr_enable_bit,
    input  logic [cache_evt_pkg::SRC_W-1:0]       wr_src,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]         counts,
    output logic                                  enable,
    output cache_evt_pkg::cnt_cfg_t [NUM_CNT-1:0] cfg,
    output logic [NUM_CNT-1:0]                    val_wr,
    output logic [CNT_W-1:0]                      rdata
);
    import cache_evt_pkg::*;

    logic do_wr, do_rd;
    logic [CNT_W-1:0] rd_mux;

    assign do_wr = bus_sel && bus_wr;
    assign do_rd = bus_sel && !bus_wr;

    always_ff @(posedge clk) begin
        if (rst)
            enable <= 1'b0;
        else if (do_wr && bus_addr == OFS_CTRL)
            enable <= wr_enable_bit;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg[i].src <= '0;
            else if (do_wr && bus_addr == cfg_ofs(i))
                cfg[i].src <= wr_src;
        end
        assign val_wr[i] = do_wr && (bus_addr == val_ofs(i));
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFS_CTRL)
            rd_mux = CNT_W'(enable);
        for (int i = 0; i < NUM_CNT; i++) begin
            if (bus_addr == cfg_ofs(i))
                rd_mux = CNT_W'(cfg[i].src) << SRC_LSB;
            if (bus_addr == val_ofs(i))
                rd_mux = counts[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= do_rd ? rd_mux : '0;
    end
endmodule

// File: rtl/cache_evt_counters.sv
module cache_evt_counters #(
    parameter int CNT_W        = 32,
    parameter int NUM_CNT      = 2,
    parameter int NUM_EVT      = 15,
    parameter int BASE_EVT_MAX = 9,
    parameter bit EXTENDED     = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [cache_evt_pkg::ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]                  bus_wdata,
    output logic [CNT_W-1:0]                  bus_rdata,
    input  logic [NUM_EVT-1:0]                evt_in
);
    import cache_evt_pkg::*;

    logic                         en_q;
    cnt_cfg_t [NUM_CNT-1:0]       cfg_q;
    logic [NUM_CNT-1:0][SRC_W-1:0] src_q;
    logic [NUM_CNT-1:0]           val_wr;
    logic [NUM_CNT-1:0]           evt_hit;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

    cache_evt_regbank #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .wr_enable_bit(bus_wdata[0]),
        .wr_src       (bus_wdata[SRC_LSB +: SRC_W]),
        .counts       (cnt_q),
        .enable       (en_q),
        .cfg          (cfg_q),
        .val_wr       (val_wr),
        .rdata        (bus_rdata)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign src_q[i] = cfg_q[i].src;

        cache_evt_select #(
            .NUM_EVT(NUM_EVT), .BASE_EVT_MAX(BASE_EVT_MAX), .EXTENDED(EXTENDED)
        ) u_sel (
            .src   (cfg_q[i].src),
            .evt_in(evt_in),
            .hit   (evt_hit[i])
        );

        cache_evt_sat_counter #(.CNT_W(CNT_W)) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .inc     (en_q && evt_hit[i]),
            .load    (val_wr[i]),
            .load_val(bus_wdata),
            .count   (cnt_q[i])
        );
    end
endmodule

// File: rtl/cache_evt_checker.sv
module cache_evt_checker #(
    parameter int CNT_W   = 32,
    parameter int NUM_CNT = 2
) (
    input logic                                       clk,
    input logic                                       rst,
    input logic                                       en,
    input logic [NUM_CNT-1:0][cache_evt_pkg::SRC_W-1:0] src,
    input logic [NUM_CNT-1:0]                         val_wr,
    input logic [CNT_W-1:0]                           wdata,
    input logic [NUM_CNT-1:0][CNT_W-1:0]              counts
);
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        p_sat_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (!val_wr[i] && counts[i] == {CNT_W{1'b1}}) |=> counts[i] == {CNT_W{1'b1}});

        p_gate_off_r4: assert property (@(posedge clk) disable iff (rst)
            (!val_wr[i] && !en) |=> $stable(counts[i]));

        p_src_off_r5: assert property (@(posedge clk) disable iff (rst)
            (!val_wr[i] && src[i] == '0) |=> $stable(counts[i]));

        p_single_step_r6: assert property (@(posedge clk) disable iff (rst)
            !val_wr[i] |=> (counts[i] == $past(counts[i]) ||
                            counts[i] == $past(counts[i]) + CNT_W'(1)));

        p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
            val_wr[i] |=> counts[i] == $past(wdata));
    end
endmodule

bind cache_evt_counters cache_evt_checker #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en_q),
    .src   (src_q),
    .val_wr(val_wr),
    .wdata (bus_wdata),
    .counts(cnt_q)
);

// File: tb/cache_evt_counters_test.sv
module cache_evt_counters_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata_b;
    logic [14:0] evt_in = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_CTRL = 8'h00, A_CFG1 = 8'h04, A_CFG0 = 8'h08,
                           A_VAL1 = 8'h0C, A_VAL0 = 8'h10;

    always #10 clk = ~clk;

    cache_evt_counters uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata), .evt_in(evt_in));

    cache_evt_counters #(.EXTENDED(1'b0)) uut_base (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .evt_in(evt_in));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] db);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = rdata; db = rdata_b;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input int code, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            evt_in = '0; evt_in[code-1] = 1'b1;
            @(negedge clk);
            evt_in = '0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d, db;
        check("R1 rdata", rdata, 32'h0);
        rd(A_CTRL, d, db); check("R1 ctrl", d, 0);
        rd(A_CFG0, d, db); check("R1 cfg0", d, 0);
        rd(A_CFG1, d, db); check("R1 cfg1", d, 0);
        rd(A_VAL0, d, db); check("R1 val0", d, 0);
        rd(A_VAL1, d, db); check("R1 val1", d, 0);
    endtask

    task automatic t_map();
        logic [31:0] d, db;
        wr(A_CFG0, 32'h0000_000F);          // src 3, irq bits set
        rd(A_CFG0, d, db); check("R2/R10 cfg0 src only", d, 32'h0C);
        wr(A_CFG1, 32'h14);
        rd(A_CFG1, d, db); check("R2 cfg1", d, 32'h14);
        wr(A_VAL0, 32'h55); wr(A_VAL1, 32'hAA);
        rd(A_VAL0, d, db); check("R2/R8 val0", d, 32'h55);
        rd(A_VAL1, d, db); check("R2/R8 val1", d, 32'hAA);
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d, db); check("R2 ctrl upper zero", d, 32'h1);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_gate();
        logic [31:0] d, db;
        wr(A_CFG0, 3 << 2); wr(A_VAL0, 0); wr(A_CTRL, 0);
        pulse(3, 3);
        rd(A_VAL0, d, db); check("R4 disabled", d, 0);
        wr(A_CTRL, 1);
        pulse(3, 3);
        rd(A_VAL0, d, db); check("R4 enabled", d, 3);
    endtask

    task automatic t_select();
        logic [31:0] d, db;
        wr(A_CFG0, 3 << 2); wr(A_CFG1, 7 << 2);
        wr(A_VAL0, 0); wr(A_VAL1, 0);
        pulse(3, 2); pulse(7, 1); pulse(1, 1); pulse(9, 1);
        rd(A_VAL0, d, db); check("R6 code3", d, 2);
        rd(A_VAL1, d, db); check("R6 code7", d, 1);
    endtask

    task automatic t_src_off();
        logic [31:0] d, db;
        wr(A_CFG1, 0); wr(A_VAL1, 32'h40);
        for (int c = 1; c <= 15; c++) pulse(c, 1);
        rd(A_VAL1, d, db); check("R5 src off", d, 32'h40);
    endtask

    task automatic t_ext();
        logic [31:0] d, db;
        wr(A_CFG0, 32'hB << 2); wr(A_CFG1, 9 << 2);
        wr(A_VAL0, 0); wr(A_VAL1, 0);
        pulse(11, 2); pulse(15, 1); pulse(9, 1);
        rd(A_VAL0, d, db);
        check("R7 extended code B", d, 2);
        check("R7 base code B ignored", db, 0);
        rd(A_VAL1, d, db);
        check("R7 extended code 9", d, 1);
        check("R7 base code 9", db, 1);
    endtask

    task automatic t_sat();
        logic [31:0] d, db;
        wr(A_CFG0, 3 << 2); wr(A_VAL0, 32'hFFFF_FFFD);
        pulse(3, 5);
        rd(A_VAL0, d, db); check("R3 saturate", d, 32'hFFFF_FFFF);
        wr(A_VAL0, 0); pulse(3, 1);
        rd(A_VAL0, d, db); check("R8 resume after clear", d, 1);
    endtask

    task automatic t_collide();
        logic [31:0] d, db;
        wr(A_CFG0, 3 << 2);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_VAL0; bus_wdata = 32'h100;
        evt_in = '0; evt_in[2] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; evt_in = '0;
        rd(A_VAL0, d, db); check("R9 write wins", d, 32'h100);
        pulse(3, 1);
        rd(A_VAL0, d, db); check("R9 resume", d, 32'h101);
    endtask

    task automatic t_unmapped();
        logic [31:0] d, db;
        rd(8'h14, d, db); check("R10 unmapped 0x14", d, 0);
        rd(8'h20, d, db); check("R10 unmapped 0x20", d, 0);
        rd(8'h02, d, db); check("R10 unmapped 0x02", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_gate();
        t_select();
        t_src_off();
        t_ext();
        t_sat();
        t_collide();
        t_unmapped();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule